// File: doc/BRIEF.md
# Receive-enable seed generator

This block prepares the starting point for DQS receive-enable training on one DIMM. It is started for a single DIMM and works through the eight byte lanes in turn. Each lane's seed delay is derived from a value read out of an external delay table. In the first training pass the seed comes from the write-levelling result. In the second pass it comes from the earlier receive-enable result, moved back by one unit interval and rescaled from the previous memory clock speed to the current one.

Delays are counted in 1/32 of a clock. The phy can only hold a small coarse delay, so each seed is split in two. The phy-loadable part keeps the fine bits and a coarse value of 1 or 2, chosen by the parity of the seed's coarse count. The leftover coarse delay goes to a result table, where later logic uses it to reassemble the trained delay. The loadable part is written to both the phy recovery-delay port and the receive-enable delay port.

Top module: `rxen_seed_gen`

## Requirements
- R1: After an accepted start, exactly eight write sets are issued, one per lane, in ascending lane order. Every write address is {dimm, lane}, with the lane in the low three bits. The read address for each lane uses the same encoding.
- R2: With passTwo low, the write-levelling table is read (rdFromRxTable=0) and the seed is the read value plus 0x3B, modulo 2^16.
- R3: With passTwo high, the receive-enable table is read (rdFromRxTable=1). The seed is ((read value - 0x20) mod 2^16) times curSpeed, divided by prevSpeed, floored and truncated to 16 bits.
- R4: The 7-bit phy value has bits [4:0] equal to seed bits [4:0]. Its bits [6:5] are 01 when seed bit 5 is set and 10 otherwise.
- R5: The table value is computed in 16-bit arithmetic. Take (seed AND 0x1E0), subtract 0x20 when seed bit 5 is set or 0x40 when it is clear, then shift the result left by 6.
- R6: For each lane, the phy recovery-delay port and the receive-enable delay port are written in the same cycle as the table, with the same address and the same 7-bit data.
- R7: done is a single-cycle pulse in the cycle after the last lane's write. busy is high from the cycle after the start until done ends.
- R8: A start while busy is high is ignored: the run in progress keeps its DIMM, its pass and its count of eight writes.
- R9: While reset is asserted, and afterwards until a start, no write enable, busy or done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run for dimmSel (sampled when idle) |
| passTwo | input | 1 | 0: first-pass seeds, 1: second-pass rescaled seeds |
| dimmSel | input | 2 | DIMM to process |
| curSpeed | input | 16 | Current memory clock speed |
| prevSpeed | input | 16 | Speed of the earlier pass (non-zero) |
| rdAddr | output | 5 | Table read address {dimm, lane} |
| rdFromRxTable | output | 1 | Selects receive-enable table (1) or write-levelling table (0) |
| rdData | input | 16 | Combinational read data for rdAddr |
| phyWrEn | output | 1 | Phy recovery-delay write strobe |
| phyWrAddr | output | 5 | Phy recovery-delay write address |
| phyWrData | output | 7 | Loadable seed {coarse, fine} |
| rxenWrEn | output | 1 | Receive-enable delay write strobe |
| rxenWrAddr | output | 5 | Receive-enable delay write address |
| rxenWrData | output | 7 | Loadable seed {coarse, fine} |
| tblWrEn | output | 1 | Result table write strobe |
| tblWrAddr | output | 5 | Result table write address |
| tblWrData | output | 16 | Shifted leftover coarse delay |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest cases are the wrap-around ones. In the even-parity case the masked coarse bits are zero and the leftover subtraction goes negative. In the second pass a stored result below one unit interval makes the rescale run on a wrapped 16-bit value. Neither shows up with ordinary delays. The stimulus table places base delays of 0xFFC5 and 0x0010 so that lane 0 lands exactly on these cases, and it steps the base across lanes so that both parities occur within one run. A start pulse injected partway through a long second-pass run, and a reset asserted mid-run, cover the ignore and quiet-state rules.

// File: rtl/rxen_seed_pkg.sv
package rxen_seed_pkg;
  localparam int FINE_W = 5;
  localparam int PHY_W  = FINE_W + 2;

  typedef struct packed {
    logic latch;    // capture speeds at an accepted start
    logic capture;  // load seed or product from rdData
    logic divStep;  // one restoring-divider step
    logic write;    // issue the lane's write set
  } ctrlStrobes_t;
endpackage

// File: rtl/rxen_seed_ctrl.sv
module rxen_seed_ctrl
  import rxen_seed_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DIMM_W = 2,
  parameter int DIV_CYC = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic                            passTwo,
  input  logic [DIMM_W-1:0]               dimmSel,
  output ctrlStrobes_t                    strobes,
  output logic                            passR,
  output logic [DIMM_W+$clog2(LANES)-1:0] laneAddr,
  output logic                            busy,
  output logic                            done
);
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(DIV_CYC + 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
  localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(DIV_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_DIV, S_WRITE, S_FIN} state_t;

  state_t state;
  logic [LANE_W-1:0] lane;
  logic [CNT_W-1:0]  divCnt;
  logic [DIMM_W-1:0] dimmR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      lane   <= '0;
      divCnt <= '0;
      dimmR  <= '0;
      passR  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          passR <= passTwo;
          dimmR <= dimmSel;
          lane  <= '0;
          state <= S_READ;
        end
        S_READ: begin
          divCnt <= '0;
          state  <= passR ? S_DIV : S_WRITE;
        end
        S_DIV: begin
          divCnt <= divCnt + 1'b1;
          if (divCnt == LAST_STEP) state <= S_WRITE;
        end
        S_WRITE: begin
          if (lane == LAST_LANE) state <= S_FIN;
          else begin
            lane  <= lane + 1'b1;
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latch   = (state == S_IDLE) && start;
    strobes.capture = (state == S_READ);
    strobes.divStep = (state == S_DIV);
    strobes.write   = (state == S_WRITE);
  end

  assign laneAddr = {dimmR, lane};
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
endmodule

// File: rtl/rxen_seed_dp.sv
module rxen_seed_dp
  import rxen_seed_pkg::*;
#(
  parameter int TBL_W = 16,
  parameter int SPD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               passR,
  input  logic [SPD_W-1:0]   curSpeed,
  input  logic [SPD_W-1:0]   prevSpeed,
  input  logic [TBL_W-1:0]   rdData,
  output logic [PHY_W-1:0]   phyVal,
  output logic [TBL_W-1:0]   tblVal
);
  localparam int PROD_W = TBL_W + SPD_W;
  localparam logic [TBL_W-1:0] ADD_P1    = TBL_W'(16'h3B);
  localparam logic [TBL_W-1:0] ONE_UI    = TBL_W'(16'h20);
  localparam logic [TBL_W-1:0] TWO_UI    = TBL_W'(16'h40);
  localparam logic [TBL_W-1:0] COARSE_MK = TBL_W'(16'h1E0);
  localparam int REM_SHIFT = 6;

  logic [SPD_W-1:0]  curR, prevR;
  logic [PROD_W-1:0] quo;
  logic [SPD_W-1:0]  remR;

  logic [TBL_W-1:0]  rxAdj;
  logic [PROD_W-1:0] product;
  logic [SPD_W:0]    shifted, trial;

  assign rxAdj   = rdData - ONE_UI;
  assign product = PROD_W'(rxAdj) * PROD_W'(curR);
  assign shifted = {remR, quo[PROD_W-1]};
  assign trial   = shifted - {1'b0, prevR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curR  <= '0;
      prevR <= '0;
      quo   <= '0;
      remR  <= '0;
    end else begin
      if (strobes.latch) begin
        curR  <= curSpeed;
        prevR <= prevSpeed;
      end
      if (strobes.capture) begin
        remR <= '0;
        quo  <= passR ? product : PROD_W'(rdData + ADD_P1);
      end else if (strobes.divStep) begin
        if (!trial[SPD_W]) begin
          remR <= trial[SPD_W-1:0];
          quo  <= {quo[PROD_W-2:0], 1'b1};
        end else begin
          remR <= shifted[SPD_W-1:0];
          quo  <= {quo[PROD_W-2:0], 1'b0};
        end
      end
    end
  end

  logic [TBL_W-1:0] seed, coarseBits, leftover;
  logic             oddCoarse;

  always_comb begin
    seed       = quo[TBL_W-1:0];
    oddCoarse  = seed[FINE_W];
    coarseBits = seed & COARSE_MK;
    leftover   = coarseBits - (oddCoarse ? ONE_UI : TWO_UI);
    tblVal     = leftover << REM_SHIFT;
    phyVal     = {(oddCoarse ? 2'b01 : 2'b10), seed[FINE_W-1:0]};
  end
endmodule

// File: rtl/rxen_seed_gen.sv
module rxen_seed_gen
  import rxen_seed_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DIMM_W = 2,
  parameter int TBL_W  = 16,
  parameter int SPD_W  = 16,
  localparam int ADDR_W = DIMM_W + $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              passTwo,
  input  logic [DIMM_W-1:0] dimmSel,
  input  logic [SPD_W-1:0]  curSpeed,
  input  logic [SPD_W-1:0]  prevSpeed,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdFromRxTable,
  input  logic [TBL_W-1:0]  rdData,
  output logic              phyWrEn,
  output logic [ADDR_W-1:0] phyWrAddr,
  output logic [PHY_W-1:0]  phyWrData,
  output logic              rxenWrEn,
  output logic [ADDR_W-1:0] rxenWrAddr,
  output logic [PHY_W-1:0]  rxenWrData,
  output logic              tblWrEn,
  output logic [ADDR_W-1:0] tblWrAddr,
  output logic [TBL_W-1:0]  tblWrData,
  output logic              busy,
  output logic              done
);
  ctrlStrobes_t       strobes;
  logic               passR;
  logic [ADDR_W-1:0]  laneAddr;
  logic [PHY_W-1:0]   phyVal;
  logic [TBL_W-1:0]   tblVal;

  rxen_seed_ctrl #(.LANES(LANES), .DIMM_W(DIMM_W), .DIV_CYC(TBL_W + SPD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .passTwo(passTwo), .dimmSel(dimmSel),
    .strobes(strobes), .passR(passR), .laneAddr(laneAddr), .busy(busy), .done(done)
  );

  rxen_seed_dp #(.TBL_W(TBL_W), .SPD_W(SPD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .passR(passR),
    .curSpeed(curSpeed), .prevSpeed(prevSpeed), .rdData(rdData),
    .phyVal(phyVal), .tblVal(tblVal)
  );

  assign rdAddr        = laneAddr;
  assign rdFromRxTable = passR;
  assign phyWrEn       = strobes.write;
  assign rxenWrEn      = strobes.write;
  assign tblWrEn       = strobes.write;
  assign phyWrAddr     = laneAddr;
  assign rxenWrAddr    = laneAddr;
  assign tblWrAddr     = laneAddr;
  assign phyWrData     = phyVal;
  assign rxenWrData    = phyVal;
  assign tblWrData     = tblVal;
endmodule

// File: rtl/rxen_seed_chk.sv
module rxen_seed_chk #(
  parameter int ADDR_W = 5,
  parameter int PHY_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              phyWrEn,
  input logic              rxenWrEn,
  input logic              tblWrEn,
  input logic [ADDR_W-1:0] phyWrAddr,
  input logic [ADDR_W-1:0] rxenWrAddr,
  input logic [ADDR_W-1:0] tblWrAddr,
  input logic [PHY_W-1:0]  phyWrData,
  input logic [PHY_W-1:0]  rxenWrData
);
  a_r6_paired_write: assert property (@(posedge clk) disable iff (!rstN)
    phyWrEn |-> (rxenWrEn && tblWrEn && phyWrAddr == rxenWrAddr &&
                 phyWrAddr == tblWrAddr && phyWrData == rxenWrData));

  a_r4_coarse_legal: assert property (@(posedge clk) disable iff (!rstN)
    phyWrEn |-> (phyWrData[PHY_W-1:PHY_W-2] == 2'b01 || phyWrData[PHY_W-1:PHY_W-2] == 2'b10));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!phyWrEn && !rxenWrEn && !tblWrEn && !done));

  a_r1_one_write_per_lane: assert property (@(posedge clk) disable iff (!rstN)
    phyWrEn |=> !phyWrEn);
endmodule

bind rxen_seed_gen rxen_seed_chk #(.ADDR_W(ADDR_W), .PHY_W(rxen_seed_pkg::PHY_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .phyWrEn(phyWrEn), .rxenWrEn(rxenWrEn), .tblWrEn(tblWrEn),
  .phyWrAddr(phyWrAddr), .rxenWrAddr(rxenWrAddr), .tblWrAddr(tblWrAddr),
  .phyWrData(phyWrData), .rxenWrData(rxenWrData)
);

// File: tb/rxen_seed_gen_tb.sv
module rxen_seed_gen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic passTwo = 1'b0;
  logic [1:0]  dimmSel = '0;
  logic [15:0] curSpeed = 16'd400, prevSpeed = 16'd400;
  logic [4:0]  rdAddr;
  logic        rdFromRxTable;
  logic [15:0] rdData;
  logic        phyWrEn, rxenWrEn, tblWrEn, busy, done;
  logic [4:0]  phyWrAddr, rxenWrAddr, tblWrAddr;
  logic [6:0]  phyWrData, rxenWrData;
  logic [15:0] tblWrData;

  always #2.5 clk = ~clk;

  logic [15:0] wlTbl [32];
  logic [15:0] rxTbl [32];
  assign rdData = rdFromRxTable ? rxTbl[rdAddr] : wlTbl[rdAddr];

  rxen_seed_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .passTwo(passTwo), .dimmSel(dimmSel),
    .curSpeed(curSpeed), .prevSpeed(prevSpeed), .rdAddr(rdAddr),
    .rdFromRxTable(rdFromRxTable), .rdData(rdData),
    .phyWrEn(phyWrEn), .phyWrAddr(phyWrAddr), .phyWrData(phyWrData),
    .rxenWrEn(rxenWrEn), .rxenWrAddr(rxenWrAddr), .rxenWrData(rxenWrData),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .busy(busy), .done(done)
  );

  int nChecks = 0, nFails = 0;
  int nCap = 0;
  logic [4:0]  capAddr [16];
  logic [4:0]  capRxAddr [16];
  logic [6:0]  capPhy [16];
  logic [6:0]  capRx [16];
  logic [15:0] capTbl [16];
  logic        capFromRx [16];

  always @(negedge clk) begin
    if (phyWrEn && nCap < 16) begin
      capAddr[nCap]   = tblWrAddr;
      capRxAddr[nCap] = rxenWrAddr;
      capPhy[nCap]    = phyWrData;
      capRx[nCap]     = rxenWrData;
      capTbl[nCap]    = tblWrData;
      capFromRx[nCap] = rdFromRxTable;
      nCap++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seedOf(bit p2, logic [15:0] d, logic [15:0] c, logic [15:0] pv);
    logic [31:0] r;
    if (!p2) return d + 16'h3B;
    r = {16'b0, d - 16'h20};
    r = (r * {16'b0, c}) / {16'b0, pv};
    return r[15:0];
  endfunction

  function automatic logic [6:0] phyOf(logic [15:0] s);
    return {(s[5] ? 2'b01 : 2'b10), s[4:0]};
  endfunction

  function automatic logic [15:0] remOf(logic [15:0] s);
    logic [15:0] t;
    t = (s & 16'h1E0) - (s[5] ? 16'h20 : 16'h40);
    return t << 6;
  endfunction

  task automatic runOne(bit p2, logic [1:0] d, logic [15:0] c, logic [15:0] pv);
    int wd = 0;
    nCap = 0;
    @(negedge clk);
    passTwo = p2; dimmSel = d; curSpeed = c; prevSpeed = pv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", 32'(busy), 32'd1);
    while (!done && wd < 3000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 3000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    check("R7 write count at done", nCap, 8);
    @(negedge clk);
    check("R7 done one cycle", 32'(done), 32'd0);
    check("R7 busy ends", 32'(busy), 32'd0);
  endtask

  localparam int NV = 6;
  localparam bit          V_P2   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [1:0]  V_DIMM [NV] = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd2};
  localparam logic [15:0] V_CUR  [NV] = '{16'd400, 16'd400, 16'd1066, 16'd1333, 16'd400, 16'd533};
  localparam logic [15:0] V_PREV [NV] = '{16'd400, 16'd400, 16'd800, 16'd1066, 16'd400, 16'd400};
  localparam logic [15:0] V_BASE [NV] = '{16'h0000, 16'hFFC5, 16'h0050, 16'h0010, 16'h01A0, 16'h0105};

  initial begin
    for (int i = 0; i < 32; i++) begin wlTbl[i] = '0; rxTbl[i] = '0; end
    repeat (3) @(negedge clk);
    // R9: quiet while and after reset
    check("R9 busy in reset", 32'(busy), 0);
    check("R9 write in reset", 32'(phyWrEn | rxenWrEn | tblWrEn | done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle after reset", 32'(busy | done | phyWrEn), 0);

    for (int v = 0; v < NV; v++) begin
      for (int l = 0; l < 8; l++) begin
        wlTbl[{V_DIMM[v], 3'(l)}] = V_BASE[v] + 16'(l * 'h29);
        rxTbl[{V_DIMM[v], 3'(l)}] = V_BASE[v] + 16'(l * 'h29);
      end
      runOne(V_P2[v], V_DIMM[v], V_CUR[v], V_PREV[v]);
      for (int l = 0; l < 8; l++) begin
        logic [15:0] s;
        s = seedOf(V_P2[v], V_BASE[v] + 16'(l * 'h29), V_CUR[v], V_PREV[v]);
        check("R1 lane address order", 32'(capAddr[l]), 32'({V_DIMM[v], 3'(l)}));
        check(V_P2[v] ? "R3 table select" : "R2 table select", 32'(capFromRx[l]), 32'(V_P2[v]));
        check(V_P2[v] ? "R3/R4 phy seed" : "R2/R4 phy seed", 32'(capPhy[l]), 32'(phyOf(s)));
        check("R5 leftover", 32'(capTbl[l]), 32'(remOf(s)));
        check("R6 rxen data", 32'(capRx[l]), 32'(capPhy[l]));
        check("R6 rxen addr", 32'(capRxAddr[l]), 32'(capAddr[l]));
      end
    end

    // R8: start during a busy second-pass run with another dimm
    for (int l = 0; l < 8; l++) rxTbl[{2'd1, 3'(l)}] = 16'h0120 + 16'(l);
    nCap = 0;
    @(negedge clk);
    passTwo = 1'b1; dimmSel = 2'd1; curSpeed = 16'd800; prevSpeed = 16'd400; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    passTwo = 1'b0; dimmSel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int wd = 0;
      while (!done && wd < 3000) begin @(negedge clk); wd++; end
      if (wd >= 3000) begin nChecks++; nFails++; $display("FAIL watchdog actual=timeout expected=done"); end
    end
    @(negedge clk);
    check("R8 write count", nCap, 8);
    for (int l = 0; l < 8; l++) begin
      check("R8 dimm kept", 32'(capAddr[l]), 32'({2'd1, 3'(l)}));
      check("R8 pass kept", 32'(capPhy[l]),
            32'(phyOf(seedOf(1'b1, 16'h0120 + 16'(l), 16'd800, 16'd400))));
    end

    // R9: reset in the middle of a run
    @(negedge clk);
    passTwo = 1'b1; dimmSel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 reset mid-run busy", 32'(busy), 0);
    check("R9 reset mid-run writes", 32'(phyWrEn | tblWrEn | done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stays idle", 32'(busy | phyWrEn), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule